// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Flushable Buffer

This block receives 8N1 asynchronous serial frames (one start bit, eight data bits least significant bit first, one stop bit). The serial input first passes through a two-flop synchronizer. It is then sampled once per pulse of an external oversampling tick. A bit lasts 16 ticks in normal mode and 8 ticks in double-speed mode. The receiver aligns to the first low sample that follows at least one idle-high sample. Each bit value is the majority vote of three samples taken around the bit centre.

Each received byte is written, together with a framing-error mark, into a two-entry buffer. A data-available flag stays high while any unread byte remains, and a one-cycle read strobe pops the oldest byte. When a byte arrives and the buffer is full, that byte is discarded and a sticky overrun flag is set. Dropping the receive enable stops reception on the next clock: any partial frame is lost, the buffer is emptied, and line activity is ignored until the enable returns.

Top module: `uart_rx_os`

## Requirements
- R1: After reset the available flag and the overrun flag are 0. Reception starts only after the synchronized line has been sampled high at least once while idle.
- R2: With double-speed select at 0, one bit lasts 16 ticks. A frame is low start bit, eight data bits with bit 0 first, then stop bit. Each received byte is delivered unchanged.
- R3: With double-speed select at 1, one bit lasts 8 ticks, and frames are delivered unchanged at that rate.
- R4: Each bit value is the majority of its samples 8, 9 and 10 (of 16), or 4, 5 and 6 (of 8), counting the start-detect sample as sample 1 of the start bit. A single corrupted sample inside a bit does not change the received byte.
- R5: If the start-bit vote is high, the start is rejected as a glitch. No byte is produced and the receiver returns to idle.
- R6: A stop-bit vote of low stores a framing-error mark of 1 with that byte. A high stop bit stores 0. The mark is read on the framing-error output next to the byte.
- R7: The buffer holds two bytes in arrival order. The available flag is 1 while at least one unread byte is held. A read strobe while available pops the oldest byte. The head byte and its mark are shown on the outputs.
- R8: A byte that completes while the buffer is full, and no read is made in that cycle, is dropped and sets the overrun flag. The flag stays set until the next read that pops a byte, which clears it.
- R9: With the enable low at a clock edge, after that edge the buffer is empty, the overrun flag is 0, and any partly received frame is discarded.
- R10: While the enable is low, frames on the line produce no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick_i | input | 1 | One-cycle sample enable at the oversampling rate |
| dbl_spd_i | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| rx_en_i | input | 1 | Receiver enable; low aborts, flushes and ignores the line |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| rd_i | input | 1 | Read strobe, pops the head byte |
| rx_avail_o | output | 1 | Unread data present |
| rx_data_o | output | 8 | Head byte of the buffer |
| rx_ferr_o | output | 1 | Framing-error mark of the head byte |
| rx_ovr_o | output | 1 | Sticky overrun flag |

## Verification
Frames are sent with alternating, all-zero and all-one data patterns at both oversampling rates. A wrong bit length or bit order therefore shows up as a changed byte. Frames with one flipped sample at a bit centre show whether the design votes or takes a single sample. A short low pulse with a high vote checks start rejection, and a low stop bit checks the per-byte error mark. Three unread frames, disabling with a full buffer, disabling in the middle of a frame, and a frame sent while disabled separate overrun dropping, flushing, aborting and ignoring the line.

// File: rtl/uart_rx_os_pkg.sv
package uart_rx_os_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // two-of-three vote used for every bit
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // ticks in one bit for the selected speed
  function automatic int unsigned bit_samples(input logic dbl, input int unsigned os_norm);
    return dbl ? (os_norm / 2) : os_norm;
  endfunction

  // sample index of the first of the three centre samples
  function automatic int unsigned first_vote(input int unsigned spb);
    return spb / 2;
  endfunction

endpackage

// File: rtl/uart_rx_os_sync.sv
module uart_rx_os_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], d_i};
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/uart_rx_os_frame.sv
module uart_rx_os_frame
  import uart_rx_os_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OS_NORM = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              dbl_i,
  input  logic              rxs_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o
);
  localparam int unsigned CNT_W = $clog2(OS_NORM + 1);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bidx;
  logic [DATA_W-1:0] shreg;
  logic              armed;
  logic              smp_a, smp_b;

  logic [CNT_W-1:0]  spb, nxt_cnt, v_lo;
  logic              smp_evt, start_evt, vote_evt, vote;

  assign spb       = CNT_W'(bit_samples(dbl_i, OS_NORM));
  assign v_lo      = CNT_W'(first_vote(32'(spb)));
  assign nxt_cnt   = (cnt >= spb) ? CNT_W'(1) : cnt + CNT_W'(1);
  assign smp_evt   = tick_i && (st != RX_IDLE);
  assign start_evt = tick_i && (st == RX_IDLE) && armed && !rxs_i;
  assign vote_evt  = smp_evt && (nxt_cnt == v_lo + CNT_W'(2));
  assign vote      = maj3(smp_a, smp_b, rxs_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      shreg  <= '0;
      armed  <= 1'b0;
      smp_a  <= 1'b1;
      smp_b  <= 1'b1;
      push_o <= 1'b0;
      data_o <= '0;
      ferr_o <= 1'b0;
    end else if (!en_i) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      armed  <= 1'b0;
      push_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        if (st == RX_IDLE) begin
          if (rxs_i) armed <= 1'b1;
          else if (start_evt) begin
            st  <= RX_START;
            cnt <= CNT_W'(1);
          end
        end else begin
          cnt <= nxt_cnt;
          if (nxt_cnt == v_lo)              smp_a <= rxs_i;
          if (nxt_cnt == v_lo + CNT_W'(1))  smp_b <= rxs_i;
          if (vote_evt) begin
            unique case (st)
              RX_START: begin
                if (vote) begin
                  st    <= RX_IDLE;
                  armed <= 1'b1;
                end else begin
                  st   <= RX_DATA;
                  bidx <= '0;
                end
              end
              RX_DATA: begin
                shreg <= {vote, shreg[DATA_W-1:1]};
                bidx  <= bidx + IDX_W'(1);
                if (bidx == LAST_IDX) st <= RX_STOP;
              end
              RX_STOP: begin
                push_o <= 1'b1;
                data_o <= shreg;
                ferr_o <= !vote;
                armed  <= vote;
                st     <= RX_IDLE;
              end
              default: st <= RX_IDLE;
            endcase
          end
        end
      end
    end
  end

  // R9: a disabled receiver never completes a byte
  a_r9_no_push_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !push_o);
  // R5: a high start vote sends the receiver back to idle
  a_r5_glitch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && st == RX_START && vote_evt && vote) |=> (st == RX_IDLE));
  // R6: the stop vote produces a byte whose mark is the inverted vote
  a_r6_stop_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && st == RX_STOP && vote_evt) |=> (push_o && (ferr_o == !$past(vote))));
  // R1: no start is taken before a high idle sample
  a_r1_need_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && !armed && en_i) |=> (st == RX_IDLE));
endmodule

// File: rtl/uart_rx_os_fifo.sv
module uart_rx_os_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic         avail_o,
  output logic [W-1:0] head_o,
  output logic         ovr_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             do_pop, do_push, drop_evt;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign do_pop   = rd_i && (count != '0);
  assign do_push  = push_i && ((count != FULL) || do_pop);
  assign drop_evt = push_i && !do_push;

  always_ff @(posedge clk) begin
    if (do_push && !flush_i) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr_o <= 1'b0;
    end else if (flush_i) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr_o <= 1'b0;
    end else begin
      if (do_push) wptr <= wrap_inc(wptr);
      if (do_pop)  rptr <= wrap_inc(rptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      if (drop_evt)    ovr_o <= 1'b1;
      else if (do_pop) ovr_o <= 1'b0;
    end
  end

  assign avail_o = (count != '0);
  assign head_o  = mem[rptr];

  // R7: occupancy never exceeds the depth
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  // R7: an accepted byte without a pop raises the occupancy by one
  a_r7_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && do_push && !do_pop) |=> (count == $past(count) + CNT_W'(1)));
  // R9: flush empties the buffer and clears the overrun flag
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!avail_o && !ovr_o));
  // R8: a dropped byte sets overrun
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && drop_evt) |=> ovr_o);
  // R8: a pop clears overrun
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !drop_evt) |=> !ovr_o);
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OS_NORM     = 16,
  parameter int unsigned BUF_DEPTH   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick_i,
  input  logic              dbl_spd_i,
  input  logic              rx_en_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  output logic              rx_avail_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ferr_o,
  output logic              rx_ovr_o
);
  localparam int unsigned ENT_W = DATA_W + 1;

  logic              rxs;
  logic              byte_push;
  logic [DATA_W-1:0] byte_data;
  logic              byte_ferr;
  logic [ENT_W-1:0]  head;

  uart_rx_os_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rxd_i),
    .q_o   (rxs)
  );

  uart_rx_os_frame #(.DATA_W(DATA_W), .OS_NORM(OS_NORM)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (rx_en_i),
    .tick_i (os_tick_i),
    .dbl_i  (dbl_spd_i),
    .rxs_i  (rxs),
    .push_o (byte_push),
    .data_o (byte_data),
    .ferr_o (byte_ferr)
  );

  uart_rx_os_fifo #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (!rx_en_i),
    .push_i  (byte_push),
    .wdata_i ({byte_ferr, byte_data}),
    .rd_i    (rd_i),
    .avail_o (rx_avail_o),
    .head_o  (head),
    .ovr_o   (rx_ovr_o)
  );

  assign rx_data_o = head[DATA_W-1:0];
  assign rx_ferr_o = head[DATA_W];
endmodule

// File: tb/test_uart_rx_os.sv
module test_uart_rx_os;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic dbl = 1'b0;
  logic en = 1'b1;
  logic rxd = 1'b1;
  logic rd_mon = 1'b0;
  logic rd_man = 1'b0;
  logic rd;
  logic avail, ferr, ovr;
  logic [7:0] data;

  int compared = 0;
  int mismatched = 0;
  logic mon_en = 1'b0;
  int tcnt = 0;

  typedef struct {
    logic [7:0] d;
    logic       fe;
    string      tag;
  } exp_t;
  exp_t q[$];

  assign rd = rd_mon | rd_man;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 3);
  end

  uart_rx_os i_uart_rx_os (
    .clk(clk), .rst_n(rst_n), .os_tick_i(tick), .dbl_spd_i(dbl),
    .rx_en_i(en), .rxd_i(rxd), .rd_i(rd), .rx_avail_o(avail),
    .rx_data_o(data), .rx_ferr_o(ferr), .rx_ovr_o(ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic v);
    rxd = v;
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b1);
  endtask

  task automatic send(input logic [7:0] d, input logic stop, input int noise_bit,
                      input logic expect_it, input string tag);
    int spb;
    exp_t e;
    spb = dbl ? 8 : 16;
    if (expect_it) begin
      e.d = d; e.fe = !stop; e.tag = tag;
      q.push_back(e);
    end
    idle(2);
    for (int b = 0; b < 10; b++) begin
      logic val;
      val = (b == 0) ? 1'b0 : (b == 9) ? stop : d[b-1];
      for (int s = 1; s <= spb; s++) begin
        if ((b - 1 == noise_bit) && (s == spb / 2 + 1)) put(!val);
        else put(val);
      end
    end
    idle(2);
  endtask

  task automatic man_read();
    rd_man = 1'b1;
    @(negedge clk);
    rd_man = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops expected items as the design presents bytes
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && avail) begin
        if (q.size() == 0) chk("R7 unexpected byte", {24'd0, data}, 32'hFFFF_FFFF);
        else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " data"}, {24'd0, data}, {24'd0, e.d});
          chk({e.tag, " ferr"}, {31'd0, ferr}, {31'd0, e.fe});
        end
        rd_mon = 1'b1;
        @(negedge clk);
        rd_mon = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset avail", {31'd0, avail}, 0);
    chk("R1 reset ovr", {31'd0, ovr}, 0);
    mon_en = 1'b1;

    // normal speed patterns
    send(8'hA5, 1'b1, -1, 1'b1, "R2 a5");
    send(8'h3C, 1'b1, -1, 1'b1, "R2 3c");
    send(8'h00, 1'b1, -1, 1'b1, "R2 00");
    send(8'hFF, 1'b1, -1, 1'b1, "R2 ff");
    // one flipped sample per byte at the centre
    send(8'h96, 1'b1, 3, 1'b1, "R4 noise16");
    // framing error
    send(8'h5A, 1'b0, -1, 1'b1, "R6 ferr");
    idle(4);
    // glitch start: three low samples then high
    put(1'b0); put(1'b0); put(1'b0);
    idle(30);
    chk("R5 glitch no byte", {31'd0, avail}, 0);
    send(8'h81, 1'b1, -1, 1'b1, "R5 after glitch");

    // double speed
    dbl = 1'b1;
    idle(4);
    send(8'h5A, 1'b1, -1, 1'b1, "R3 5a");
    send(8'hC3, 1'b1, -1, 1'b1, "R3 c3");
    send(8'h69, 1'b1, 6, 1'b1, "R4 noise8");
    send(8'h18, 1'b0, -1, 1'b1, "R6 ferr8");
    dbl = 1'b0;
    idle(4);
    repeat (10) @(negedge clk);
    chk("R7 queue drained", q.size(), 0);

    // overrun
    mon_en = 1'b0;
    send(8'h11, 1'b1, -1, 1'b0, "");
    send(8'h22, 1'b1, -1, 1'b0, "");
    chk("R8 no ovr at two", {31'd0, ovr}, 0);
    send(8'h33, 1'b1, -1, 1'b0, "");
    chk("R7 avail full", {31'd0, avail}, 1);
    chk("R8 ovr set", {31'd0, ovr}, 1);
    chk("R7 head first", {24'd0, data}, 32'h11);
    man_read();
    chk("R8 ovr cleared", {31'd0, ovr}, 0);
    chk("R7 head second", {24'd0, data}, 32'h22);
    man_read();
    chk("R8 third dropped", {31'd0, avail}, 0);

    // disable with a full buffer
    send(8'h44, 1'b1, -1, 1'b0, "");
    send(8'h55, 1'b1, -1, 1'b0, "");
    send(8'h66, 1'b1, -1, 1'b0, "");
    chk("R8 ovr before flush", {31'd0, ovr}, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R9 flushed avail", {31'd0, avail}, 0);
    chk("R9 flushed ovr", {31'd0, ovr}, 0);
    en = 1'b1;
    idle(4);

    // abort in the middle of a frame
    for (int s = 0; s < 16; s++) put(1'b0);
    for (int s = 0; s < 48; s++) put(1'b1);
    en = 1'b0;
    for (int s = 0; s < 96; s++) put(1'b0);
    idle(4);
    en = 1'b1;
    idle(20);
    chk("R9 partial frame lost", {31'd0, avail}, 0);

    // frame while disabled
    en = 1'b0;
    send(8'h7E, 1'b1, -1, 1'b0, "");
    chk("R10 ignored while off", {31'd0, avail}, 0);
    en = 1'b1;
    idle(4);
    chk("R10 nothing after enable", {31'd0, avail}, 0);
    mon_en = 1'b1;
    send(8'hE7, 1'b1, -1, 1'b1, "R9 fresh frame");
    repeat (10) @(negedge clk);
    chk("R7 final drain", q.size(), 0);
    finish_run();
  end
endmodule